// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a half-duplex SPI master meant only for serial flash commands. Software programs three registers: a command word that packs a one-byte instruction with a 24-bit flash address, a 32-bit data word, and a control word holding a transmit byte count, a receive byte count and a go bit. The engine then lowers chip select and serialises a byte stream taken from the command and data words. Once every transmit byte has gone out, it clocks in the requested receive bytes and drops them into the data word.

The line runs in SPI mode 0 with a single device select. The serial clock half-period is a whole number of system clocks set by a parameter. A `busy` output covers the whole transfer, including a chip-select idle gap at its end. A one-cycle `done` strobe marks the cycle in which `busy` falls. Typical uses are a bare write-enable (opcode only), a status read (opcode plus one receive byte), a page-program chunk (opcode, address, four data bytes) and a read chunk (opcode, address, up to four receive bytes).

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: With transmit count 1 and receive count 0, exactly 8 SCK cycles occur while chip select is low, and MOSI carries command bits [7:0], most significant bit first.
- R2: Transmit stream byte 0 is command bits [7:0]. Bytes 1, 2 and 3 are command bits [31:24], [23:16] and [15:8], in that order. Every byte goes out MSB first.
- R3: Transmit stream bytes 4 to 7 are data-word bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R4: Received byte i, sampled MSB first, is written to data-word bits [8i+7:8i]. Data-word lanes at or above the receive count keep their previous value.
- R5: Receive bytes follow all transmit bytes. Chip select stays low for exactly (tx+rx)*8 SCK cycles, and MOSI is low during the receive bytes.
- R6: `busy` rises after a go write and falls after chip select has been released. `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R7: A control write made while `busy` is high starts no transfer and leaves the stored counts unchanged.
- R8: SCK idles low and pulses only while chip select is low. MOSI is stable at each SCK rising edge, and MISO is sampled on that edge (mode 0).
- R9: Between the release of chip select and the start of the next transfer, chip select stays high for at least 2*HALF_DIV system clock cycles.
- R10: The register select codes are 0 (control), 1 (command) and 2 (data). The control word holds the transmit count in bits [3:0], the receive count in bits [11:8], and go (write) or busy (read) in bit 31. A transmit count of 0 is stored as 1 and a value above 8 is stored as 8. A receive count above 4 is stored as 4. The control word reads back the stored counts.
- R11: After reset, chip select is high, SCK is low, `busy` and `done` are low, and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| busy | output | 1 | Transfer in progress, including the release gap |
| done | output | 1 | One-cycle end-of-transfer strobe |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low device select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that `reg_sel` holds one of the three defined codes whenever `reg_wr` is high. They also assume that `spi_miso` is stable around each SCK rising edge. The bench's flash model changes MISO only when chip select falls or SCK falls, and it writes only the three defined registers. The transfer-ignored check relies on the go write arriving after `busy` has been seen high, so the bench waits for `busy` before it issues the second write.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CTL_TX_LSB = 0;
  localparam int CTL_RX_LSB = 8;
  localparam int CTL_GO_BIT = 31;
  localparam int CTL_FW     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int HALF_DIV = 2,
  localparam int CW = $clog2(HALF_DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == CW'(HALF_DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(HALF_DIV - 1));
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int TX_MAX = 8,
  parameter int RX_MAX = 4,
  localparam int TXC_W = $clog2(TX_MAX + 1),
  localparam int RXC_W = $clog2(RX_MAX + 1),
  localparam int LANE_W = (RX_MAX > 1) ? $clog2(RX_MAX) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [1:0]          sel,
  input  logic [31:0]         wdata,
  input  logic                busy,
  input  logic                rx_we,
  input  logic [LANE_W-1:0]   rx_lane,
  input  logic [7:0]          rx_byte,
  output logic [31:0]         rdata,
  output logic                start,
  output logic [TXC_W-1:0]    tx_n,
  output logic [RXC_W-1:0]    rx_n,
  output logic [31:0]         cmd_q,
  output logic [8*RX_MAX-1:0] data_q
);
  logic [CTL_FW-1:0] f_tx, f_rx;
  logic [TXC_W-1:0]  tx_c;
  logic [RXC_W-1:0]  rx_c;
  logic [31:0]       ctrl_view;
  logic              ctrl_wr, locked;

  // field clamping
  always_comb begin
    f_tx = wdata[CTL_TX_LSB +: CTL_FW];
    f_rx = wdata[CTL_RX_LSB +: CTL_FW];
    if (f_tx == '0) tx_c = TXC_W'(1);
    else if (int'(f_tx) > TX_MAX) tx_c = TXC_W'(TX_MAX);
    else tx_c = TXC_W'(f_tx);
    if (int'(f_rx) > RX_MAX) rx_c = RXC_W'(RX_MAX);
    else rx_c = RXC_W'(f_rx);
  end

  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign locked  = busy || start;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_TX_LSB +: TXC_W] = tx_n;
    ctrl_view[CTL_RX_LSB +: RXC_W] = rx_n;
    ctrl_view[CTL_GO_BIT] = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_n   <= '0;
      rx_n   <= '0;
      start  <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      start <= 1'b0;
      if (ctrl_wr && !locked) begin
        tx_n  <= tx_c;
        rx_n  <= rx_c;
        start <= wdata[CTL_GO_BIT];
      end
      if (wr && sel == SEL_CMD) cmd_q <= wdata;
      if (wr && sel == SEL_DATA) data_q <= wdata[8*RX_MAX-1:0];
      if (rx_we) data_q[8*rx_lane +: 8] <= rx_byte;
      case (sel)
        SEL_CTRL: rdata <= ctrl_view;
        SEL_CMD:  rdata <= cmd_q;
        SEL_DATA: rdata <= 32'(data_q);
        default:  rdata <= '0;
      endcase
    end
  end

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> ($stable(tx_n) && $stable(rx_n))); // R7
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R7
  AST_TX_RANGE: assert property (@(posedge clk) disable iff (rst)
    start |-> (tx_n != '0 && int'(tx_n) <= TX_MAX && int'(rx_n) <= RX_MAX)); // R10
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int TX_MAX = 8,
  parameter int RX_MAX = 4,
  parameter int HALF_DIV = 2,
  localparam int TXC_W = $clog2(TX_MAX + 1),
  localparam int RXC_W = $clog2(RX_MAX + 1),
  localparam int LANE_W = (RX_MAX > 1) ? $clog2(RX_MAX) : 1,
  localparam int BI_W = $clog2(TX_MAX + RX_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [TXC_W-1:0]    tx_n,
  input  logic [RXC_W-1:0]    rx_n,
  input  logic [8*TX_MAX-1:0] tx_flat,
  input  logic                miso,
  output logic                sck,
  output logic                cs_n,
  output logic                mosi,
  output logic                busy,
  output logic                done,
  output logic                rx_we,
  output logic [LANE_W-1:0]   rx_lane,
  output logic [7:0]          rx_byte
);
  eng_state_e       state;
  logic [7:0]       tx_q [TX_MAX];
  logic [TXC_W-1:0] tx_len;
  logic [RXC_W-1:0] rx_len;
  logic [BI_W-1:0]  byte_idx, nxt_byte, last_byte;
  logic [2:0]       bit_idx, nxt_bit;
  logic [6:0]       rx_sh;
  logic             gap_half, tick, run, in_rx, at_last, nxt_mosi;

  assign run = (state != ST_IDLE);

  spi_eng_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  always_comb begin
    last_byte = BI_W'(tx_len) + BI_W'(rx_len) - BI_W'(1);
    in_rx     = (byte_idx >= BI_W'(tx_len));
    at_last   = (byte_idx == last_byte) && (bit_idx == 3'd0);
    nxt_bit   = bit_idx - 3'd1;
    nxt_byte  = (bit_idx == 3'd0) ? byte_idx + BI_W'(1) : byte_idx;
    nxt_mosi  = 1'b0;
    for (int i = 0; i < TX_MAX; i++)
      if (nxt_byte == BI_W'(i) && nxt_byte < BI_W'(tx_len)) nxt_mosi = tx_q[i][nxt_bit];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_we    <= 1'b0;
      rx_lane  <= '0;
      rx_byte  <= '0;
      byte_idx <= '0;
      bit_idx  <= 3'd7;
      rx_sh    <= '0;
      gap_half <= 1'b0;
      tx_len   <= '0;
      rx_len   <= '0;
      for (int i = 0; i < TX_MAX; i++) tx_q[i] <= '0;
    end else begin
      done  <= 1'b0;
      rx_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            for (int i = 0; i < TX_MAX; i++) tx_q[i] <= tx_flat[8*i +: 8];
            tx_len   <= tx_n;
            rx_len   <= rx_n;
            byte_idx <= '0;
            bit_idx  <= 3'd7;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            mosi     <= tx_flat[7];
            state    <= ST_LEAD;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck   <= 1'b1;
              state <= ST_SHIFT;
              if (in_rx) begin
                rx_sh <= {rx_sh[5:0], miso};
                if (bit_idx == 3'd0) begin
                  rx_we   <= 1'b1;
                  rx_lane <= LANE_W'(byte_idx - BI_W'(tx_len));
                  rx_byte <= {rx_sh, miso};
                end
              end
            end else begin
              sck <= 1'b0;
              if (at_last) begin
                state <= ST_TRAIL;
                mosi  <= 1'b0;
              end else begin
                bit_idx  <= nxt_bit;
                byte_idx <= nxt_byte;
                mosi     <= nxt_mosi;
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n     <= 1'b1;
            gap_half <= 1'b0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              gap_half <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // chip-select idle window measured independently of the state machine
  logic [15:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (rst) gap_cnt <= '1;
    else if (!cs_n) gap_cnt <= '0;
    else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6
  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy); // R5
  AST_MOSI_QUIET_RX: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && in_rx) |-> !mosi); // R5
  AST_LANE_OK: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> (int'(rx_lane) < RX_MAX)); // R4
  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (int'(gap_cnt) >= 2*HALF_DIV)); // R9
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine #(
  parameter int ADDR_BYTES = 3,
  parameter int DATA_BYTES = 4,
  parameter int HALF_DIV   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        done,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int TX_MAX = 1 + ADDR_BYTES + DATA_BYTES;
  localparam int RX_MAX = DATA_BYTES;
  localparam int TXC_W  = $clog2(TX_MAX + 1);
  localparam int RXC_W  = $clog2(RX_MAX + 1);
  localparam int LANE_W = (RX_MAX > 1) ? $clog2(RX_MAX) : 1;

  logic                start, rx_we;
  logic [TXC_W-1:0]    tx_n;
  logic [RXC_W-1:0]    rx_n;
  logic [31:0]         cmd_q;
  logic [8*RX_MAX-1:0] data_q;
  logic [LANE_W-1:0]   rx_lane;
  logic [7:0]          rx_byte;
  logic [8*TX_MAX-1:0] tx_flat;

  // transmit stream: opcode, address high to low, data lanes low to high
  assign tx_flat[7:0] = cmd_q[7:0];
  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
    assign tx_flat[8*(1+a) +: 8] = cmd_q[31-8*a -: 8];
  end
  for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
    assign tx_flat[8*(1+ADDR_BYTES+d) +: 8] = data_q[8*d +: 8];
  end

  spi_eng_regs #(.TX_MAX(TX_MAX), .RX_MAX(RX_MAX)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .busy    (busy),
    .rx_we   (rx_we),
    .rx_lane (rx_lane),
    .rx_byte (rx_byte),
    .rdata   (reg_rdata),
    .start   (start),
    .tx_n    (tx_n),
    .rx_n    (rx_n),
    .cmd_q   (cmd_q),
    .data_q  (data_q)
  );

  spi_eng_shifter #(.TX_MAX(TX_MAX), .RX_MAX(RX_MAX), .HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tx_n    (tx_n),
    .rx_n    (rx_n),
    .tx_flat (tx_flat),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .busy    (busy),
    .done    (done),
    .rx_we   (rx_we),
    .rx_lane (rx_lane),
    .rx_byte (rx_byte)
  );
endmodule

// File: tb/spi_flash_cmd_engine_tb.sv
module spi_flash_cmd_engine_tb;
  import spi_eng_pkg::*;
  localparam int HALF_DIV = 2;

  logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, spi_miso = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, done, spi_sck, spi_cs_n, spi_mosi;

  always #2 clk = ~clk;

  spi_flash_cmd_engine #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0, cyc = 0, frames = 0, bit_cnt = 0, cur_tx = 1, cs_rise_cyc = -1;
  logic [7:0] exp_q[$];
  int         exp_frame_q[$];
  logic [7:0] resp [4];
  logic [7:0] sh;
  logic       stray = 1'b0, in_frame = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  // flash model: drives MISO only on CS fall or SCK fall
  task automatic drive_miso();
    int base = cur_tx * 8;
    if (bit_cnt >= base && bit_cnt < base + 32)
      spi_miso = resp[(bit_cnt - base) / 8][7 - ((bit_cnt - base) % 8)];
    else
      spi_miso = 1'b0;
  endtask

  always @(negedge spi_cs_n) begin
    bit_cnt = 0; sh = '0; stray = 1'b0; in_frame = 1'b1;
    if (cs_rise_cyc >= 0) chk(cyc - cs_rise_cyc >= 2*HALF_DIV, "R9", "cs idle gap", cyc - cs_rise_cyc, 2*HALF_DIV);
    drive_miso();
  end

  always @(negedge spi_sck) drive_miso();

  // monitor: scoreboard pop per completed MOSI byte
  always @(posedge spi_sck) begin
    if (spi_cs_n) stray = 1'b1;
    sh = {sh[6:0], spi_mosi};
    bit_cnt++;
    if (bit_cnt % 8 == 0) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected mosi byte", sh, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(sh == e, "R1/R2/R3/R5", "mosi byte", sh, e);
      end
    end
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      int ef;
      in_frame = 1'b0;
      ef = (exp_frame_q.size() != 0) ? exp_frame_q.pop_front() : -1;
      chk(bit_cnt == ef, "R5", "sck cycles in frame", bit_cnt, ef);
      chk(!stray, "R8", "sck outside cs", stray, 0);
      frames++;
      cs_rise_cyc = cyc;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        chk(!busy && prev_busy, "R6", "done at busy fall", {busy, prev_busy}, 2'b01);
        chk(!prev_done, "R6", "done single cycle", prev_done, 0);
      end
      prev_busy = busy;
      prev_done = done;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s;
    @(negedge clk); v = reg_rdata;
  endtask

  function automatic logic [7:0] stream_byte(input logic [31:0] cmd, data, input int k);
    if (k == 0) return cmd[7:0];
    if (k <= 3) return cmd[31 - 8*(k-1) -: 8];
    return data[8*(k-4) +: 8];
  endfunction

  function automatic logic [31:0] ctrl_word(input int txf, rxf, input bit go);
    logic [31:0] w = '0;
    w[3:0] = 4'(txf); w[11:8] = 4'(rxf); w[31] = go;
    return w;
  endfunction

  task automatic push_exp(input logic [31:0] cmd, data, input int tx, rx, input logic [31:0] rsp);
    for (int k = 0; k < tx; k++) exp_q.push_back(stream_byte(cmd, data, k));
    for (int k = 0; k < rx; k++) exp_q.push_back(8'h00);
    exp_frame_q.push_back((tx + rx) * 8);
    cur_tx = tx;
    for (int i = 0; i < 4; i++) resp[i] = rsp[8*i +: 8];
  endtask

  task automatic xfer(input logic [31:0] cmd, data, input int txf, rxf, input logic [31:0] rsp);
    int tx = (txf == 0) ? 1 : (txf > 8 ? 8 : txf);
    int rx = (rxf > 4) ? 4 : rxf;
    logic [31:0] v, expd;
    push_exp(cmd, data, tx, rx, rsp);
    wr(SEL_CMD, cmd);
    wr(SEL_DATA, data);
    wr(SEL_CTRL, ctrl_word(txf, rxf, 1'b1));
    @(posedge done); @(negedge clk);
    for (int i = 0; i < 4; i++) expd[8*i +: 8] = (i < rx) ? rsp[8*i +: 8] : data[8*i +: 8];
    rd(SEL_DATA, v);
    chk(v == expd, "R4", "data word after transfer", v, expd);
    rd(SEL_CTRL, v);
    chk(v == ctrl_word(tx, rx, 1'b0), "R10", "stored counts", v, ctrl_word(tx, rx, 1'b0));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(spi_cs_n === 1'b1, "R11", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R11", "sck after reset", spi_sck, 0);
    chk(busy === 1'b0 && done === 1'b0, "R11", "busy/done after reset", {busy, done}, 0);
    rd(SEL_CTRL, v);
    chk(v == 32'h0, "R11", "control after reset", v, 0);

    xfer(32'h0000_0006, 32'h1111_2222, 1, 0, 32'h0);            // R1 opcode only
    xfer(32'hABCD_EF03, 32'h0, 4, 4, 32'h4433_2211);            // R2 address order, R4 full read
    xfer(32'h1234_5602, 32'hA1B2_C3D4, 8, 0, 32'h0);            // R3 data little-endian
    xfer(32'h0000_009F, 32'hDEAD_BEEF, 1, 3, 32'h007C_6B5A);    // R4 lane retained
    xfer(32'h0102_030B, 32'h5566_7788, 15, 7, 32'hC3C2_C1C0);   // R10 clamp high
    xfer(32'h0000_0005, 32'hFFFF_FF00, 0, 1, 32'h0000_0080);    // R10 tx 0 -> 1

    // R7: go write while busy is ignored
    f0 = frames;
    push_exp(32'h7766_5502, 32'h0BAD_F00D, 8, 0, 32'h0);
    wr(SEL_CMD, 32'h7766_5502);
    wr(SEL_DATA, 32'h0BAD_F00D);
    wr(SEL_CTRL, ctrl_word(8, 0, 1'b1));
    while (!busy) @(negedge clk);
    wr(SEL_CTRL, ctrl_word(1, 2, 1'b1));
    @(posedge done);
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R7", "frames after busy go write", frames, f0 + 1);
    chk(exp_q.size() == 0, "R7", "leftover expected bytes", exp_q.size(), 0);
    rd(SEL_CTRL, v);
    chk(v == ctrl_word(8, 0, 1'b0), "R7", "counts kept", v, ctrl_word(8, 0, 1'b0));
    finish_run();
  end
endmodule